// File: doc/BRIEF.md
# Eviction-Marked Prefetch Trigger

This block sits beside a fetch target buffer and remembers which instruction cache blocks were thrown out while the predictor still refers to them. Each predictor entry covers a fetch range that can span several cache blocks, and the block keeps one evict bit for each of those block slots. When the instruction cache evicts a block, it sends a notice that names the owning predictor entry and the slot within that entry. The block then sets the matching bit.

When the predictor later selects that entry, every set bit of the entry is put out as a prefetch request in the same cycle as the prediction. The bits that were issued are then cleared. Because the request leaves at prediction time, it does not wait for a free cache port. The request is one entry index plus a mask of slots, so the memory side can start the fetches from there. When the predictor writes a new entry over an old one, the old entry's marks are dropped. The predictor lookup and the memory side are not part of this block.

Top module: `evict_prefetch_trigger`

## Requirements
- R1: After reset every evict bit is clear, so a prediction of any entry gives `pf_valid` = 0 and `pf_mask` = 0.
- R2: An eviction notice with `evict_valid` = 1 and an offset k below the slot count (3 by default) sets bit k of the entry `evict_idx`. Bit k of `pf_mask` stands for slot k.
- R3: If a prediction selects an entry that has set bits, then in that same cycle `pf_valid` = 1, `pf_idx` equals `pred_idx`, and `pf_mask` holds exactly the entry's set bits.
- R4: A prediction of an entry with no set bits, or a cycle with no prediction, gives `pf_valid` = 0 and `pf_mask` = 0.
- R5: Every bit that goes out in a prefetch is cleared, so the next prediction of that entry gives no prefetch unless a new eviction sets a bit again.
- R6: An eviction notice whose offset is equal to or greater than the slot count changes no bit. With the default of 3 slots, offset 3 is out of range.
- R7: An eviction and a prediction for the same entry in the same cycle apply the eviction first, so the new bit is part of that cycle's `pf_mask`.
- R8: A replacement (`repl_valid`) clears all bits of entry `repl_idx`. An eviction for the same entry in the same cycle is applied after the clear and is kept. A prediction in that cycle sees the entry only after the clear.
- R9: Notices, predictions and replacements change only the entry they name. The bits of every other entry keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_valid | input | 1 | An eviction notice is present |
| evict_idx | input | IDX_W (6) | Predictor entry that owns the evicted block |
| evict_off | input | OFF_W (2) | Slot of the evicted block within that entry |
| repl_valid | input | 1 | The predictor entry is being replaced |
| repl_idx | input | IDX_W (6) | Entry being replaced |
| pred_valid | input | 1 | The predictor selects an entry this cycle |
| pred_idx | input | IDX_W (6) | Entry selected |
| pf_valid | output | 1 | A prefetch request is issued |
| pf_idx | output | IDX_W (6) | Entry the request belongs to |
| pf_mask | output | SLOTS (3) | Slots to prefetch, bit k meaning slot k |

## Verification
A wrong stored bit shows up only when its entry is next predicted. A lost mark then appears as a missing `pf_mask` bit, and a stray or stale mark appears as an extra prefetch. The delay can therefore be long, so the bench predicts entries often over a small index range, and any error in storage shows at the ports within a few cycles. A mistake in the order of work inside one cycle, such as a missed forward, a replace that runs after the evict, or a clear applied to the wrong entry, shows in the same cycle or the next. For this reason the outputs are compared with a model on every cycle, and the mixes of requests that meet on one entry are driven on purpose.

// File: rtl/evp_pkg.sv
package evp_pkg;
    parameter int ENTRIES = 64;
    parameter int SLOTS   = 3;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int OFF_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef logic [SLOTS-1:0] slot_mask_t;
endpackage

// File: rtl/evp_slot_decode.sv
module evp_slot_decode
    import evp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [OFF_W-1:0] off,
    output slot_mask_t       onehot
);
    always_comb begin
        onehot = '0;
        if (valid && (int'(off) < SLOTS))
            onehot[off] = 1'b1;
    end

    // R6: out-of-range offsets never produce a slot
    a_r6_no_stray_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(off) >= SLOTS) |-> (onehot == '0));
    // R2: a valid in-range offset produces exactly one slot
    a_r2_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && int'(off) < SLOTS) |-> $onehot0(onehot) && (onehot != '0));
endmodule

// File: rtl/evp_entry.sv
module evp_entry
    import evp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  slot_mask_t set_mask,
    input  logic       rd,
    output slot_mask_t eff
);
    slot_mask_t bits_q;
    slot_mask_t bits_d;

    // replace first, then eviction, then the prediction consumes
    always_comb begin
        eff    = (clr ? '0 : bits_q) | set_mask;
        bits_d = rd ? '0 : eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    // R5: nothing survives an issuing read
    a_r5_clear_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> ((bits_q & $past(eff)) == '0));
    // R2: a mark set without a read is held
    a_r2_mark_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && set_mask != '0) |=> ((bits_q & $past(set_mask)) == $past(set_mask)));
    // R8: a replace with nothing new leaves the entry empty
    a_r8_replace_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_mask == '0) |=> (bits_q == '0));
    // R9: an untouched entry keeps its bits
    a_r9_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rd && set_mask == '0) |=> $stable(bits_q));
endmodule

// File: rtl/evict_prefetch_trigger.sv
module evict_prefetch_trigger
    import evp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic [OFF_W-1:0] evict_off,
    input  logic             repl_valid,
    input  logic [IDX_W-1:0] repl_idx,
    input  logic             pred_valid,
    input  logic [IDX_W-1:0] pred_idx,
    output logic             pf_valid,
    output logic [IDX_W-1:0] pf_idx,
    output logic [SLOTS-1:0] pf_mask
);
    slot_mask_t evict_onehot;
    slot_mask_t eff_arr [ENTRIES];

    evp_slot_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (evict_valid),
        .off    (evict_off),
        .onehot (evict_onehot)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic       clr_e;
        logic       rd_e;
        slot_mask_t set_e;

        always_comb begin
            clr_e = repl_valid && (repl_idx == IDX_W'(e));
            rd_e  = pred_valid && (pred_idx == IDX_W'(e));
            set_e = (evict_idx == IDX_W'(e)) ? evict_onehot : '0;
        end

        evp_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_e),
            .set_mask (set_e),
            .rd       (rd_e),
            .eff      (eff_arr[e])
        );
    end

    always_comb begin
        pf_idx   = pred_idx;
        pf_mask  = pred_valid ? eff_arr[pred_idx] : '0;
        pf_valid = pred_valid && (pf_mask != '0);
    end

    // R4: no prediction, no prefetch
    a_r4_needs_pred: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> (!pf_valid && pf_mask == '0));
    // R3: a request always names at least one slot
    a_r3_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_mask != '0));
    // R7: a same-cycle eviction on the predicted entry is forwarded
    a_r7_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && evict_valid && evict_idx == pred_idx && int'(evict_off) < SLOTS)
        |-> pf_mask[evict_off]);
    // R5: an entry predicted twice in a row with no new mark gives nothing the second time
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !(evict_valid && evict_idx == pred_idx)) && $past(pred_valid)
        && $past(rst_n) && ($past(pred_idx) == pred_idx) |-> !pf_valid);
endmodule

// File: tb/test_evict_prefetch_trigger.sv
`timescale 1ns/1ps
module test_evict_prefetch_trigger;
    import evp_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evict_valid = 1'b0;
    logic [IDX_W-1:0] evict_idx = '0;
    logic [OFF_W-1:0] evict_off = '0;
    logic             repl_valid = 1'b0;
    logic [IDX_W-1:0] repl_idx = '0;
    logic             pred_valid = 1'b0;
    logic [IDX_W-1:0] pred_idx = '0;
    logic             pf_valid;
    logic [IDX_W-1:0] pf_idx;
    logic [SLOTS-1:0] pf_mask;

    int total = 0;
    int bad = 0;
    int model [ENTRIES];

    always #2.5 clk = ~clk;

    evict_prefetch_trigger i_evict_prefetch_trigger (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_idx(evict_idx), .evict_off(evict_off),
        .repl_valid(repl_valid), .repl_idx(repl_idx),
        .pred_valid(pred_valid), .pred_idx(pred_idx),
        .pf_valid(pf_valid), .pf_idx(pf_idx), .pf_mask(pf_mask)
    );

    task automatic step(input bit ev, input int ei, input int eo,
                        input bit rv, input int ri,
                        input bit pv, input int pi, input string req);
        int exp_mask;
        bit exp_valid;
        @(negedge clk);
        evict_valid = ev; evict_idx = IDX_W'(ei); evict_off = OFF_W'(eo);
        repl_valid = rv;  repl_idx = IDX_W'(ri);
        pred_valid = pv;  pred_idx = IDX_W'(pi);
        #1;
        exp_mask = 0;
        if (pv) begin
            exp_mask = (rv && ri == pi) ? 0 : model[pi];
            if (ev && ei == pi && eo < SLOTS) exp_mask |= (1 << eo);
        end
        exp_valid = (exp_mask != 0);
        total++;
        if (pf_valid !== exp_valid || int'(pf_mask) !== exp_mask
            || (pv && pf_idx !== IDX_W'(pi))) begin
            bad++;
            $display("FAIL %s: got valid=%0b idx=%0d mask=%0h, expected valid=%0b idx=%0d mask=%0h",
                     req, pf_valid, pf_idx, pf_mask, exp_valid, pi, exp_mask);
        end
        if (rv) model[ri] = 0;
        if (ev && eo < SLOTS) model[ei] |= (1 << eo);
        if (pv) model[pi] = 0;
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, every entry empty
        for (int i = 0; i < ENTRIES; i += 9) step(0, 0, 0, 0, 0, 1, i, "R1");
        // R2 and R3: mark slots then predict
        step(1, 5, 0, 0, 0, 0, 0, "R2");
        step(1, 5, 2, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, 5, "R3");
        // R5: issued bits gone
        step(0, 0, 0, 0, 0, 1, 5, "R5");
        // R4: prediction with no marks
        step(0, 0, 0, 0, 0, 1, 7, "R4");
        // R6: offset 3 ignored
        step(1, 9, 3, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 1, 9, "R6");
        // R7: same-cycle forward
        step(1, 11, 1, 0, 0, 1, 11, "R7");
        step(0, 0, 0, 0, 0, 1, 11, "R7");
        // R8: replace clears, same-cycle eviction kept
        step(1, 12, 0, 0, 0, 0, 0, "R8");
        step(1, 12, 1, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 12, 1, 12, "R8");
        step(1, 13, 0, 0, 0, 0, 0, "R8");
        step(1, 13, 2, 1, 13, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 13, "R8");
        // R9: neighbours untouched
        step(1, 20, 1, 0, 0, 0, 0, "R9");
        step(1, 21, 0, 1, 22, 1, 19, "R9");
        step(0, 0, 0, 0, 0, 1, 20, "R9");
        step(0, 0, 0, 0, 0, 1, 21, "R9");
        // R3 R5 R7 R8 R9: mixed traffic on a few entries
        for (int n = 0; n < 3000; n++)
            step($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
                 ($urandom_range(0, 7) == 0), $urandom_range(0, 7),
                 $urandom_range(0, 1), $urandom_range(0, 7), "R3/mixed");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule